// File: doc/BRIEF.md
# Flash Bus Interface Front End

This block sits between the pins of a NOR-style flash die and its internal array and command logic. It decides when the incoming address is held for a read, and it captures the address and data of each write. It also decides when the data and wait outputs may be driven onto the shared bus. Every pin is sampled by one fast system clock. The edges of the address-valid strobe, the write strobe and the bus clock are found by comparing each sample with the previous one. None of these pins is used as a clock net.

Reads run in one of two modes. In asynchronous mode the address passes through while the address-valid strobe is low and is held once the strobe rises. In synchronous mode the address is captured once per strobe-low period. Capture happens at the first rising bus-clock edge seen while the strobe is low, or at the strobe's rising edge if that comes first. The wait output tells the host when burst data is not yet valid. Its active level comes from one bit of a configuration word. Tri-state pins are presented as a value plus a drive enable.

Top module: `flash_bus_front`

## Requirements
- R1: While `rstN` is low, `addrOut` and `wrValid` are 0 and `dataOe`/`waitOe` are 0. A write strobe edge seen during reset produces no write. After reset the read mode is asynchronous.
- R2: In asynchronous mode, while `advN` is low, `addrOut` equals the `addrIn` sampled on the previous system clock edge.
- R3: In asynchronous mode, the sample in which `advN` is first seen high loads `addrIn`. Later `addrIn` changes are ignored while `advN` stays high.
- R4: In synchronous mode, after `advN` falls, the first rising `busClk` sample with `advN` low loads `addrIn`. Further bus-clock edges, address changes and the following `advN` rise leave `addrOut` unchanged.
- R5: In synchronous mode, if `advN` rises before any bus-clock rise in that low period, `addrIn` is loaded at the rise.
- R6: `dataOe` is 1 exactly when `rstN` is high and both `ceN` and `oeN` are low. `dataOut` follows `arrayData`.
- R7: `waitOe` follows the same condition as `dataOe`.
- R8: `cfgWord[10]` = 1 makes WAIT active high, and 0 makes it active low. In synchronous mode with `weN` high, WAIT is asserted while `arrayValid` is 0 and deasserted while it is 1.
- R9: In asynchronous mode, or while `weN` is low, WAIT is at its deasserted level.
- R10: A `weN` rise sampled with `ceN` low makes `wrValid` 1 for exactly one cycle. `wrAddr`/`wrData` take the `addrIn`/`dataIn` of that sample. With `ceN` high the edge is ignored.
- R11: `syncMode` (1 = synchronous) is taken into the mode register only in cycles where `ceN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low reset pin |
| addrIn | input | 16 | Address pins |
| advN | input | 1 | Active-low address-valid strobe |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write strobe |
| busClk | input | 1 | Bus clock for synchronous reads |
| dataIn | input | 16 | Data pins, input direction |
| arrayData | input | 16 | Read data from the array |
| syncMode | input | 1 | Requested read mode, 1 = synchronous |
| arrayValid | input | 1 | Array reports read data valid |
| cfgWord | input | 16 | Read configuration word |
| addrOut | output | 16 | Held read address |
| wrAddr | output | 16 | Captured write address |
| wrData | output | 16 | Captured write data |
| wrValid | output | 1 | One-cycle pulse on a captured write |
| dataOut | output | 16 | Data pin value |
| dataOe | output | 1 | Data pin drive enable |
| waitOut | output | 1 | WAIT pin value |
| waitOe | output | 1 | WAIT pin drive enable |

## Verification
Some rules need only pin values, and the checker tests them on every cycle. The output gating is checked against chip and output enable. The reset state of the outputs is checked. Each write pulse must follow a write-strobe rise with chip enable low, and it must last one cycle. WAIT must show its deasserted level whenever the write strobe is low. The read mode cannot be seen at the pins, so only the bench scenarios can show the rest. These cover flow-through against hold, capture on the first bus-clock edge against capture on the strobe rise, a mode request ignored while the chip is selected, and WAIT polarity following the configuration bit.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  typedef enum logic {
    MODE_ASYNC = 1'b0,
    MODE_SYNC  = 1'b1
  } busMode_e;

  typedef struct packed {
    logic addrLoad;    // load the read address register this cycle
    logic wrLoad;      // capture write address and data this cycle
    logic waitActive;  // WAIT should show its asserted level
  } fbfStrobe_t;
endpackage

// File: rtl/fbf_ctrl.sv
module fbf_ctrl
  import fbf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       advN,
  input  logic       weN,
  input  logic       ceN,
  input  logic       busClk,
  input  logic       syncMode,
  input  logic       arrayValid,
  output fbfStrobe_t strb
);
  logic     advQ, weQ, busClkQ, syncDone;
  busMode_e modeQ;
  logic     advRise, advFall, clkRise, weRise, doneEff, syncCapture;

  assign advRise = advN && !advQ;
  assign advFall = !advN && advQ;
  assign clkRise = busClk && !busClkQ;
  assign weRise  = weN && !weQ;

  // a new low period of the strobe re-arms synchronous capture
  assign doneEff     = syncDone && !advFall;
  assign syncCapture = !doneEff && ((!advN && clkRise) || advRise);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      advQ     <= 1'b1;
      weQ      <= 1'b1;
      busClkQ  <= 1'b0;
      syncDone <= 1'b0;
      modeQ    <= MODE_ASYNC;
    end else begin
      advQ    <= advN;
      weQ     <= weN;
      busClkQ <= busClk;
      if (ceN) modeQ <= busMode_e'(syncMode);
      if (modeQ == MODE_SYNC && syncCapture) syncDone <= 1'b1;
      else if (advFall)                      syncDone <= 1'b0;
    end
  end

  always_comb begin
    strb = '0;
    if (modeQ == MODE_SYNC) strb.addrLoad = syncCapture;
    else                    strb.addrLoad = !advN || advRise;
    strb.wrLoad     = weRise && !ceN;
    strb.waitActive = (modeQ == MODE_SYNC) && weN && !arrayValid;
  end
endmodule

// File: rtl/fbf_datapath.sv
module fbf_datapath
  import fbf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbfStrobe_t        strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              waitPolHigh,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrValid,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              waitOut,
  output logic              waitOe
);
  logic driveEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrOut <= '0;
      wrAddr  <= '0;
      wrData  <= '0;
      wrValid <= 1'b0;
    end else begin
      if (strb.addrLoad) addrOut <= addrIn;
      if (strb.wrLoad) begin
        wrAddr <= addrIn;
        wrData <= dataIn;
      end
      wrValid <= strb.wrLoad;
    end
  end

  assign driveEn = rstN && !ceN && !oeN;
  assign dataOe  = driveEn;
  assign waitOe  = driveEn;
  assign dataOut = arrayData;
  // asserted level equals the polarity bit, deasserted is its inverse
  assign waitOut = strb.waitActive ? waitPolHigh : !waitPolHigh;
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
  import fbf_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CFG_W   = 16,
  parameter int POL_BIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              advN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              busClk,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              syncMode,
  input  logic              arrayValid,
  input  logic [CFG_W-1:0]  cfgWord,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrValid,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              waitOut,
  output logic              waitOe
);
  fbfStrobe_t strb;
  logic       unusedCfg;

  assign unusedCfg = ^cfgWord;

  fbf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .advN(advN), .weN(weN), .ceN(ceN),
    .busClk(busClk), .syncMode(syncMode), .arrayValid(arrayValid),
    .strb(strb)
  );

  fbf_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addrIn(addrIn), .dataIn(dataIn),
    .arrayData(arrayData), .ceN(ceN), .oeN(oeN),
    .waitPolHigh(cfgWord[POL_BIT]),
    .addrOut(addrOut), .wrAddr(wrAddr), .wrData(wrData), .wrValid(wrValid),
    .dataOut(dataOut), .dataOe(dataOe), .waitOut(waitOut), .waitOe(waitOe)
  );
endmodule

// File: rtl/fbf_checker.sv
module fbf_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic              polBit,
  input logic [ADDR_W-1:0] addrOut,
  input logic              wrValid,
  input logic              dataOe,
  input logic              waitOut,
  input logic              waitOe
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (!dataOe && !waitOe));

  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (addrOut == '0 && !wrValid));

  a_r6_data_gate: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (!ceN && !oeN));

  a_r7_wait_with_data: assert property (@(posedge clk) disable iff (!rstN)
    dataOe == waitOe);

  a_r9_write_no_wait: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> (waitOut == !polBit));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

  a_r10_after_edge: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> ($past(weN) && !$past(weN, 2) && !$past(ceN)));
endmodule

bind flash_bus_front fbf_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
  .polBit(cfgWord[POL_BIT]), .addrOut(addrOut), .wrValid(wrValid),
  .dataOe(dataOe), .waitOut(waitOut), .waitOe(waitOe)
);

// File: tb/flash_bus_front_bench.sv
module flash_bus_front_bench;
  logic        clk = 1'b0;
  logic        rstN, advN, ceN, oeN, weN, busClk, syncMode, arrayValid;
  logic [15:0] addrIn, dataIn, arrayData, cfgWord;
  logic [15:0] addrOut, wrAddr, wrData, dataOut;
  logic        wrValid, dataOe, waitOut, waitOe;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  flash_bus_front u_flash_bus_front (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .advN(advN), .ceN(ceN),
    .oeN(oeN), .weN(weN), .busClk(busClk), .dataIn(dataIn),
    .arrayData(arrayData), .syncMode(syncMode), .arrayValid(arrayValid),
    .cfgWord(cfgWord), .addrOut(addrOut), .wrAddr(wrAddr), .wrData(wrData),
    .wrValid(wrValid), .dataOut(dataOut), .dataOe(dataOe),
    .waitOut(waitOut), .waitOe(waitOe)
  );

  // async address table: {advN, addrIn, expected addrOut}
  localparam logic [32:0] asyncVec [7] = '{
    {1'b0, 16'h1111, 16'h1111},
    {1'b0, 16'h2222, 16'h2222},
    {1'b1, 16'h3333, 16'h3333},
    {1'b1, 16'h4444, 16'h3333},
    {1'b0, 16'h5555, 16'h5555},
    {1'b1, 16'h6666, 16'h6666},
    {1'b1, 16'h7777, 16'h6666}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; advN = 1; ceN = 0; oeN = 0; weN = 1; busClk = 0;
    syncMode = 0; arrayValid = 0; cfgWord = 16'h0000;
    addrIn = 16'h0; dataIn = 16'h0; arrayData = 16'h5A5A;
    step(); step();
    // R1: reset state, output gating off even with selects low
    chk("R1 addrOut", addrOut, 16'h0);
    chk("R1 dataOe", dataOe, 1'b0);
    chk("R1 waitOe", waitOe, 1'b0);
    addrIn = 16'hDEAD; dataIn = 16'hBEEF; weN = 0; step();
    weN = 1; step();
    chk("R1 write inhibited", wrValid, 1'b0);
    chk("R1 wrData", wrData, 16'h0);
    // R11: mode request while selected is not taken
    syncMode = 1; step();
    rstN = 1; step();
    advN = 0; addrIn = 16'h4321; step();
    chk("R1/R11 async after reset", addrOut, 16'h4321);
    advN = 1; step();

    // R2/R3 vector table
    for (int i = 0; i < 7; i++) begin
      advN = asyncVec[i][32]; addrIn = asyncVec[i][31:16];
      step();
      chk($sformatf("R2/R3 vec%0d", i), addrOut, asyncVec[i][15:0]);
    end

    // R9: asynchronous mode keeps WAIT deasserted (active high here)
    cfgWord = 16'h0400; weN = 1; arrayValid = 0; step();
    chk("R9 async wait", waitOut, 1'b0);
    chk("R7 waitOe", waitOe, 1'b1);

    // R11: mode taken while deselected
    ceN = 1; step();
    ceN = 0; step();

    // R4: capture on first bus clock rise
    advN = 0; addrIn = 16'h1234; step();
    chk("R4 no capture before clk", addrOut, 16'h6666);
    busClk = 1; step();
    chk("R4 capture on clk", addrOut, 16'h1234);
    addrIn = 16'h5678; busClk = 0; step();
    busClk = 1; step();
    chk("R4 second clk ignored", addrOut, 16'h1234);
    advN = 1; step();
    chk("R4 adv rise ignored", addrOut, 16'h1234);

    // R5: adv rise before any clock rise
    busClk = 0; step();
    advN = 0; addrIn = 16'h9ABC; step();
    chk("R5 held during low", addrOut, 16'h1234);
    advN = 1; step();
    chk("R5 capture on adv rise", addrOut, 16'h9ABC);
    addrIn = 16'h0001; busClk = 1; step();
    chk("R5 hold after rise", addrOut, 16'h9ABC);

    // R8: polarity and data valid in synchronous mode
    arrayValid = 0; cfgWord = 16'h0400; step();
    chk("R8 active high asserted", waitOut, 1'b1);
    arrayValid = 1; step();
    chk("R8 active high deasserted", waitOut, 1'b0);
    cfgWord = 16'h0000; arrayValid = 0; step();
    chk("R8 active low asserted", waitOut, 1'b0);
    arrayValid = 1; step();
    chk("R8 active low deasserted", waitOut, 1'b1);

    // R9: write strobe low forces deasserted level
    cfgWord = 16'h0400; arrayValid = 0; weN = 0; step();
    chk("R9 write mode wait", waitOut, 1'b0);
    weN = 1; step();

    // R6/R7 gating
    arrayData = 16'hA55A; step();
    chk("R6 dataOut", dataOut, 16'hA55A);
    chk("R6 dataOe on", dataOe, 1'b1);
    oeN = 1; step();
    chk("R6 dataOe oeN high", dataOe, 1'b0);
    chk("R7 waitOe oeN high", waitOe, 1'b0);
    oeN = 0; ceN = 1; step();
    chk("R6 dataOe ceN high", dataOe, 1'b0);
    ceN = 0; step();

    // R10 write capture
    addrIn = 16'hBEEF; dataIn = 16'hCAFE; weN = 0; step();
    weN = 1; step();
    chk("R10 pulse", wrValid, 1'b1);
    chk("R10 wrAddr", wrAddr, 16'hBEEF);
    chk("R10 wrData", wrData, 16'hCAFE);
    step();
    chk("R10 pulse ends", wrValid, 1'b0);
    ceN = 1; weN = 0; step();
    addrIn = 16'h0F0F; weN = 1; step();
    chk("R10 deselected write", wrValid, 1'b0);
    chk("R10 wrAddr kept", wrAddr, 16'hBEEF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule